// File: doc/BRIEF.md
# Two-level clock phase shift controller

The block sets the phase of the clock sent out to an image sensor, measured against the internal pixel clock. Sensor data is always sampled by the internal pixel clock. The clock that comes back from the sensor plays no part, and only the outgoing clock is moved. A single write carries a phase word with two parts. The low 16 bits are a signed fine step target. Bits 17:16 pick one of four clock manager outputs that sit at 0, 90, 180 and 270 degrees.

The fine part is not loaded directly. The controller walks the clock manager's incremental phase-shift port toward the target one step at a time. It pulses an enable, holds a direction, and waits for a done pulse before it sends the next step. Each step is only nominally 20 to 40 ps, so the controller counts steps and never converts them to time. The fine target is clamped to the guaranteed range of plus or minus 140 steps. The coarse quadrant changes on the next cycle, whatever the fine stepping is doing at that moment. A write that arrives mid-walk replaces the target, and stepping goes on from the current position.

Top module: `phase_shift_ctrl`

## Requirements
- R1: After reset, fine_pos is 0, quad is 0, and busy and ps_en are low.
- R2: On the cycle after a write, quad equals bits 17:16 of wr_data. This holds even while fine stepping is in progress.
- R3: sensor_clk follows cm_clk[quad] combinationally, with quad encoded 0..3 for 0/90/180/270 degrees.
- R4: The fine target is bits 15:0 of wr_data read as a signed two's-complement value, clamped to the range -140..+140.
- R5: Each step is a single-cycle ps_en pulse. No further ps_en pulse is issued until ps_done has been received for the outstanding step.
- R6: fine_pos changes by exactly one on each ps_done that answers an outstanding step. It goes up when ps_inc=1 and down when ps_inc=0. A ps_done with no step outstanding is ignored.
- R7: A write while busy replaces the target. Stepping continues from the current fine_pos toward the newest clamped target.
- R8: busy is high from the cycle after a write until fine_pos equals the clamped target with no step outstanding. It then falls, and at that point fine_pos equals the clamped target.
- R9: ps_inc stays stable while a step is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock domain clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Phase word write strobe |
| wr_data | input | 18 | Phase word: [15:0] signed fine target, [17:16] quadrant |
| ps_en | output | 1 | One-cycle phase-step request to the clock manager |
| ps_inc | output | 1 | Step direction: 1 increment, 0 decrement |
| ps_done | input | 1 | Step completion pulse from the clock manager |
| cm_clk | input | 4 | Four clock manager outputs at 0/90/180/270 degrees |
| sensor_clk | output | 1 | Selected clock sent to the sensor |
| fine_pos | output | 9 | Current signed fine offset in steps |
| quad | output | 2 | Selected quadrant |
| busy | output | 1 | Fine walk in progress |

## Verification
The hardest situation to reach is a retarget that arrives while a step is outstanding, because the handshake latency is set by the clock manager. The bench model answers each step after a random delay of 1 to 4 cycles. Random writes are then issued a random few cycles into a walk, so they land both inside and between handshakes. A spurious done pulse is also injected while the block is idle. The clamp edges at ±140, ±141 and the extreme 16-bit values are written directly.

// File: rtl/phase_shift_ctrl.sv
module phase_shift_ctrl #(
  parameter int FINE_W   = 16,
  parameter int FINE_MAX = 140,
  localparam int POS_W   = $clog2(FINE_MAX + 1) + 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [FINE_W+1:0]       wr_data,
  output logic                    ps_en,
  output logic                    ps_inc,
  input  logic                    ps_done,
  input  logic [3:0]              cm_clk,
  output logic                    sensor_clk,
  output logic signed [POS_W-1:0] fine_pos,
  output logic [1:0]              quad,
  output logic                    busy
);

  logic signed [POS_W-1:0] tgt;
  logic                    pending;

  function automatic logic signed [POS_W-1:0] clamp(input logic signed [FINE_W-1:0] v);
    int vi;
    vi = int'(v);
    if (vi > FINE_MAX)       return POS_W'(FINE_MAX);
    else if (vi < -FINE_MAX) return POS_W'(-FINE_MAX);
    else                     return POS_W'(vi);
  endfunction

  assign sensor_clk = cm_clk[quad];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tgt      <= '0;
      fine_pos <= '0;
      quad     <= 2'd0;
      busy     <= 1'b0;
      pending  <= 1'b0;
      ps_en    <= 1'b0;
      ps_inc   <= 1'b0;
    end else begin
      ps_en <= 1'b0;
      if (pending) begin
        if (ps_done) begin
          fine_pos <= ps_inc ? fine_pos + POS_W'(1) : fine_pos - POS_W'(1);
          pending  <= 1'b0;
        end
      end else if (busy && fine_pos != tgt) begin
        ps_en   <= 1'b1;
        ps_inc  <= tgt > fine_pos;
        pending <= 1'b1;
      end else if (busy) begin
        busy <= 1'b0;
      end
      if (wr_en) begin
        tgt  <= clamp(wr_data[FINE_W-1:0]);
        quad <= wr_data[FINE_W+1:FINE_W];
        busy <= 1'b1;
      end
    end
  end

endmodule

module phase_shift_ctrl_chk #(
  parameter int FINE_MAX = 140,
  parameter int POS_W    = 9
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    ps_en,
  input logic                    ps_inc,
  input logic                    ps_done,
  input logic                    pending,
  input logic                    busy,
  input logic signed [POS_W-1:0] fine_pos,
  input logic signed [POS_W-1:0] tgt
);

  // R5
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ps_en |=> !ps_en);

  // R5
  wait_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && !ps_done) |=> !ps_en);

  // R6
  step_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && ps_done && ps_inc) |=> fine_pos == $past(fine_pos) + POS_W'(1));

  // R6
  step_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && ps_done && !ps_inc) |=> fine_pos == $past(fine_pos) - POS_W'(1));

  // R6
  hold_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(pending && ps_done) |=> $stable(fine_pos));

  // R9
  dir_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && !ps_done) |=> $stable(ps_inc));

  // R4
  tgt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(tgt) <= FINE_MAX) && (int'(tgt) >= -FINE_MAX));

  // R8
  idle_at_tgt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (fine_pos == tgt && !pending));

endmodule

bind phase_shift_ctrl phase_shift_ctrl_chk #(.FINE_MAX(FINE_MAX), .POS_W(POS_W)) chk (.*);

// File: tb/tb_phase_shift_ctrl.sv
`timescale 1ns/1ps
module tb_phase_shift_ctrl;
  logic clk = 0, rst_n = 0, wr_en = 0, ps_done = 0;
  logic [17:0] wr_data = '0;
  logic [3:0] cm_clk = '0;
  logic ps_en, ps_inc, sensor_clk, busy;
  logic signed [8:0] fine_pos;
  logic [1:0] quad;

  int total = 0, bad = 0, model_pos = 0, delay = 0, exp_tgt = 0;
  bit mdir = 0, inject = 0, finished = 0;

  phase_shift_ctrl dut (.*);

  always #2 clk = ~clk;

  function automatic int clampf(input logic [15:0] f);
    int v;
    v = $signed(f);
    return v > 140 ? 140 : (v < -140 ? -140 : v);
  endfunction

  task automatic chk(input string req, input int act, input int expv);
    total++;
    if (act != expv) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // behavioural clock manager, acts at negedges
  always @(negedge clk) begin
    ps_done = 0;
    if (inject) ps_done = 1;
    if (delay > 0) begin
      if (ps_en) chk("R5 extra step", 1, 0);
      delay--;
      if (delay == 0) begin
        ps_done = 1;
        model_pos += mdir ? 1 : -1;
      end
    end else if (ps_en) begin
      delay = 1 + int'($urandom % 4);
      mdir = ps_inc;
    end
  end

  task automatic wr(input logic [17:0] d, input string req);
    @(negedge clk);
    wr_en = 1; wr_data = d;
    @(negedge clk);
    wr_en = 0;
    exp_tgt = clampf(d[15:0]);
    chk({req, " R8 busy after write"}, busy, 1);
    chk({req, " R2 quad"}, quad, d[17:16]);
  endtask

  task automatic settle(input string req);
    int n = 0;
    while (busy && n < 5000) begin @(negedge clk); n++; end
    chk({req, " R8 busy falls"}, busy, 0);
    chk({req, " R4 R8 fine_pos"}, fine_pos, exp_tgt);
    chk({req, " R6 model phase"}, model_pos, exp_tgt);
  endtask

  initial begin
    #400000;
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 fine_pos", fine_pos, 0);
    chk("R1 quad", quad, 0);
    chk("R1 busy", busy, 0);
    chk("R1 ps_en", ps_en, 0);

    wr(18'h0_0000, "zero"); settle("zero");
    wr(18'h1_008C, "+140"); settle("+140");
    wr(18'h2_008D, "+141 clamp"); settle("+141 clamp");
    wr(18'h3_7FFF, "max clamp"); settle("max clamp");
    wr(18'h0_FF74, "-140"); settle("-140");
    wr(18'h1_FF73, "-141 clamp"); settle("-141 clamp");
    wr(18'h2_8000, "min clamp"); settle("min clamp");

    // R3 selector across all quadrants
    for (int q = 0; q < 4; q++) begin
      wr({q[1:0], 16'(q * 5)}, "R3 setup"); settle("R3 setup");
      for (int p = 0; p < 16; p += 5) begin
        cm_clk = p[3:0]; #0.5;
        chk("R3 sensor_clk", sensor_clk, cm_clk[q]);
      end
    end

    // R6 spurious done while idle
    inject = 1; @(negedge clk); inject = 0;
    @(negedge clk);
    chk("R6 spurious done pos", fine_pos, exp_tgt);
    chk("R6 spurious done busy", busy, 0);

    // R7 retarget mid walk, R2 quad change during stepping
    wr(18'h0_0064, "R7 first");
    repeat (7) @(negedge clk);
    chk("R7 walking", busy, 1);
    wr(18'h3_FFEC, "R7 retarget"); settle("R7 retarget");

    // random mix
    for (int i = 0; i < 60; i++) begin
      logic [17:0] d;
      d = 18'($urandom);
      if (i % 3 == 0) d[15:0] = 16'(int'($urandom % 361) - 180);
      wr(d, "rand R7");
      if ($urandom % 2) begin
        repeat (int'($urandom % 12)) @(negedge clk);
        d = 18'($urandom);
        d[15:0] = 16'(int'($urandom % 301) - 150);
        wr(d, "rand R7 mid");
      end
      settle("rand");
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule